// File: doc/BRIEF.md
# Configurable Ordering Store Buffer

This block sits between one in-order core and one memory port. Stores from the core are written into a small buffer and sent to memory later. Loads may go to memory before older buffered stores that are still waiting. A static mode input selects how strictly the buffer keeps order. Strict mode never returns data from the buffer. Total-order mode returns buffered data and writes stores out oldest first. Partial-order mode also returns buffered data, and it may write stores to different addresses out of order when memory refuses the store it offers.

The core has a store channel, a load channel with a registered response, and a fence channel. The fence has two kinds: a store barrier and a full serialize. On the memory side there is a store issue port and a load issue port with a response. On the store issue port, a refused offer is not a stall: in partial-order mode the buffer may offer another entry on the next cycle. The buffer holds its entries in a collapsing queue, so the entry at index 0 is always the oldest.

Top module: `sb_store_buffer`

## Requirements
- R1: After reset the buffer holds no entries. st_ready is high, mst_valid and ld_resp_valid are low, and a serialize fence (fence_kind=1) sees fence_ready high.
- R2: The buffer holds DEPTH entries (8 by default). When it is full, st_ready is low and no further store is accepted.
- R3: In every mode, a load whose word address matches no buffered store is issued on the memory load port while older stores remain unwritten. Its response carries the memory data.
- R4: In strict mode (mode=0), a load that matches a buffered store is not accepted (ld_ready low) until no matching store remains. It then reads memory and so sees the stored value.
- R5: In total-order mode (mode=1, and mode=3, which behaves the same) and in partial-order mode (mode=2), a matching load returns the youngest matching buffered data. ld_resp_valid is high in the cycle after the load handshake.
- R6: In strict and total-order modes, only the oldest entry is offered on the memory store port. A refused store is offered again, so stores reach memory in acceptance order.
- R7: In partial-order mode, after a refused offer the next cycle offers the next younger eligible entry, wrapping to the oldest. An entry is eligible when no older entry has its address and no store barrier separates it from an older entry.
- R8: In partial-order mode, stores to the same address reach memory in acceptance order, and the last one accepted sets the final memory value.
- R9: A store barrier (fence_valid with fence_kind=0) is accepted at once. No store accepted after it reaches memory before every store accepted before it.
- R10: A serialize request (fence_valid with fence_kind=1) holds fence_ready low until the buffer is empty. While it waits, no load is accepted or issued to memory and no store is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Ordering mode: 0 strict, 1 total order, 2 partial order, 3 same as 1 |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Buffer can accept the store |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core load request |
| ld_ready | output | 1 | Load accepted this cycle |
| ld_addr | input | AW | Load word address |
| ld_resp_valid | output | 1 | Load response strobe |
| ld_resp_data | output | DW | Load response data |
| fence_valid | input | 1 | Fence request |
| fence_kind | input | 1 | 0 store barrier, 1 serialize |
| fence_ready | output | 1 | Fence complete |
| mst_valid | output | 1 | Store offered to memory |
| mst_ready | input | 1 | Memory takes the offered store; low refuses it |
| mst_addr | output | AW | Offered store address |
| mst_data | output | DW | Offered store data |
| mld_valid | output | 1 | Load issued to memory |
| mld_ready | input | 1 | Memory takes the load |
| mld_addr | output | AW | Memory load address |
| mld_resp_valid | input | 1 | Memory load response strobe |
| mld_resp_data | input | DW | Memory load response data |

## Verification
The main function is driven with two stores followed by one load. The pattern changes per mode in three ways: the load matches the older store, matches both stores, or matches neither. Together these tell forwarding apart from bypass, and the youngest match apart from the oldest. In strict mode the same pattern separates a stalled load from a forwarded one. Retirement order is checked by refusing one address at the memory port. The order in which stores reach memory then tells FIFO order apart from out-of-order retirement, shows that same-address stores stay in order, and shows whether a barrier holds younger stores back.

// File: rtl/sb_pkg.sv
package sb_pkg;
   typedef enum logic [1:0] {
      ORD_STRICT = 2'd0,
      ORD_TOTAL  = 2'd1,
      ORD_PART   = 2'd2,
      ORD_ALT    = 2'd3
   } ord_mode_e;
endpackage

// File: rtl/sb_pick.sv
// Retirement selector: finds eligible entries and picks the one to offer.
module sb_pick #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]         vld,
   input  logic [DEPTH-1:0][AW-1:0] addr,
   input  logic [DEPTH-1:0]         bar,
   input  logic                     relax,
   input  logic                     skip_vld,
   input  logic [IW-1:0]            skip_idx,
   output logic                     pick_vld,
   output logic [IW-1:0]            pick_idx
);
   logic [DEPTH-1:0] elig;

   for (genvar i = 0; i < DEPTH; i++) begin : g_elig
      if (i == 0) begin : g_head
         assign elig[i] = vld[0];
      end else begin : g_body
         logic conflict, blocked;
         always_comb begin
            conflict = 1'b0;
            blocked  = vld[i] && bar[i];
            for (int j = 0; j < i; j++) begin
               if (vld[j] && addr[j] == addr[i]) conflict = 1'b1;
               if (j > 0 && vld[j] && bar[j])     blocked  = 1'b1;
            end
         end
         assign elig[i] = relax && vld[i] && !conflict && !blocked;
      end
   end

   logic          first_vld, aft_vld;
   logic [IW-1:0] first_idx, aft_idx;

   always_comb begin
      first_vld = 1'b0;
      first_idx = '0;
      aft_vld   = 1'b0;
      aft_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (elig[i]) begin
            first_vld = 1'b1;
            first_idx = IW'(i);
            if (skip_vld && IW'(i) > skip_idx) begin
               aft_vld = 1'b1;
               aft_idx = IW'(i);
            end
         end
      end
      pick_vld = first_vld;
      pick_idx = aft_vld ? aft_idx : first_idx;
   end
endmodule

// File: rtl/sb_match.sv
// Load address lookup: reports any match and the youngest matching data.
module sb_match #(
   parameter int DEPTH = 8,
   parameter int AW    = 16,
   parameter int DW    = 32
) (
   input  logic [DEPTH-1:0]         vld,
   input  logic [DEPTH-1:0][AW-1:0] addr,
   input  logic [DEPTH-1:0][DW-1:0] data,
   input  logic [AW-1:0]            ld_addr,
   output logic                     hit,
   output logic [DW-1:0]            fwd_data
);
   always_comb begin
      hit      = 1'b0;
      fwd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (vld[i] && addr[i] == ld_addr) begin
            hit      = 1'b1;
            fwd_data = data[i];
         end
      end
   end
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
   import sb_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic          ld_valid,
   output logic          ld_ready,
   input  logic [AW-1:0] ld_addr,
   output logic          ld_resp_valid,
   output logic [DW-1:0] ld_resp_data,
   input  logic          fence_valid,
   input  logic          fence_kind,
   output logic          fence_ready,
   output logic          mst_valid,
   input  logic          mst_ready,
   output logic [AW-1:0] mst_addr,
   output logic [DW-1:0] mst_data,
   output logic          mld_valid,
   input  logic          mld_ready,
   output logic [AW-1:0] mld_addr,
   input  logic          mld_resp_valid,
   input  logic [DW-1:0] mld_resp_data
);
   localparam int IW = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sb_store_buffer: DEPTH must be at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("sb_store_buffer: AW and DW must be positive");
   end

   ord_mode_e ord;
   assign ord = ord_mode_e'(mode);

   logic relax, fwd_en;
   assign relax  = (ord == ORD_PART);
   assign fwd_en = (ord != ORD_STRICT);

   // entry storage, index 0 oldest
   logic [DEPTH-1:0]         ent_vld, ent_bar;
   logic [DEPTH-1:0][AW-1:0] ent_addr;
   logic [DEPTH-1:0][DW-1:0] ent_data;

   logic ser_pend, bar_now, bar_pend_q;
   assign ser_pend    = fence_valid && fence_kind;
   assign bar_now     = fence_valid && !fence_kind;
   assign fence_ready = fence_kind ? ~|ent_vld : 1'b1;

   assign st_ready = !ent_vld[DEPTH-1] && !ser_pend;
   logic st_fire;
   assign st_fire = st_valid && st_ready;

   // load path
   logic          ld_hit, ld_busy_q, ld_can, resp_vld_q;
   logic [DW-1:0] fwd_data, resp_data_q;

   sb_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
      .vld(ent_vld), .addr(ent_addr), .data(ent_data),
      .ld_addr(ld_addr), .hit(ld_hit), .fwd_data(fwd_data)
   );

   assign ld_can        = !ld_busy_q && !ser_pend;
   assign ld_ready      = ld_can && (ld_hit ? fwd_en : mld_ready);
   assign mld_valid     = ld_valid && ld_can && !ld_hit;
   assign mld_addr      = ld_addr;
   assign ld_resp_valid = resp_vld_q;
   assign ld_resp_data  = resp_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_busy_q   <= 1'b0;
         resp_vld_q  <= 1'b0;
         resp_data_q <= '0;
      end else begin
         resp_vld_q <= 1'b0;
         if (ld_valid && ld_ready && ld_hit) begin
            resp_vld_q  <= 1'b1;
            resp_data_q <= fwd_data;
         end
         if (mld_valid && mld_ready) ld_busy_q <= 1'b1;
         if (ld_busy_q && mld_resp_valid) begin
            ld_busy_q   <= 1'b0;
            resp_vld_q  <= 1'b1;
            resp_data_q <= mld_resp_data;
         end
      end
   end

   // retirement path
   logic          pick_vld, skip_vld_q, st_ret;
   logic [IW-1:0] pick_idx, skip_idx_q;

   sb_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
      .vld(ent_vld), .addr(ent_addr), .bar(ent_bar), .relax(relax),
      .skip_vld(skip_vld_q), .skip_idx(skip_idx_q),
      .pick_vld(pick_vld), .pick_idx(pick_idx)
   );

   assign mst_valid = pick_vld;
   assign mst_addr  = ent_addr[pick_idx];
   assign mst_data  = ent_data[pick_idx];
   assign st_ret    = mst_valid && mst_ready;

   // collapse on retirement, then append at the first free slot
   logic [DEPTH-1:0]         sh_vld, sh_bar, n_vld, n_bar;
   logic [DEPTH-1:0][AW-1:0] sh_addr, n_addr;
   logic [DEPTH-1:0][DW-1:0] sh_data, n_data;
   logic                     new_bar;

   assign sh_vld  = {1'b0, ent_vld[DEPTH-1:1]};
   assign sh_bar  = {1'b0, ent_bar[DEPTH-1:1]};
   assign sh_addr = {{AW{1'b0}}, ent_addr[DEPTH-1:1]};
   assign sh_data = {{DW{1'b0}}, ent_data[DEPTH-1:1]};
   assign new_bar = bar_pend_q || (bar_now && |ent_vld);

   always_comb begin
      logic placed;
      n_vld  = ent_vld;
      n_bar  = ent_bar;
      n_addr = ent_addr;
      n_data = ent_data;
      placed = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (st_ret && !(IW'(i) < pick_idx)) begin
            n_vld[i]  = sh_vld[i];
            n_bar[i]  = sh_bar[i];
            n_addr[i] = sh_addr[i];
            n_data[i] = sh_data[i];
         end
      end
      for (int i = 0; i < DEPTH; i++) begin
         if (st_fire && !placed && !n_vld[i]) begin
            n_vld[i]  = 1'b1;
            n_bar[i]  = new_bar;
            n_addr[i] = st_addr;
            n_data[i] = st_data;
            placed    = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld    <= '0;
         ent_bar    <= '0;
         ent_addr   <= '0;
         ent_data   <= '0;
         bar_pend_q <= 1'b0;
         skip_vld_q <= 1'b0;
         skip_idx_q <= '0;
      end else begin
         ent_vld  <= n_vld;
         ent_bar  <= n_bar;
         ent_addr <= n_addr;
         ent_data <= n_data;
         if (st_fire)                     bar_pend_q <= 1'b0;
         else if (bar_now && |ent_vld)    bar_pend_q <= 1'b1;
         if (st_ret || !relax) begin
            skip_vld_q <= 1'b0;
         end else if (mst_valid) begin
            skip_vld_q <= 1'b1;
            skip_idx_q <= pick_idx;
         end
      end
   end
endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
   parameter int DEPTH = 8,
   parameter int AW    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode,
   input logic [DEPTH-1:0] ent_vld,
   input logic [AW-1:0]    head_addr,
   input logic             st_ready,
   input logic             ld_ready,
   input logic             ld_resp_valid,
   input logic             mld_valid,
   input logic             mld_resp_valid,
   input logic             fence_valid,
   input logic             fence_kind,
   input logic             mst_valid,
   input logic [AW-1:0]    mst_addr
);
   // R2
   full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&ent_vld) |-> !st_ready);

   // R4
   strict_no_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && ld_resp_valid) |-> $past(mld_resp_valid));

   // R10
   serialize_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fence_valid && fence_kind && |ent_vld) |-> (!mld_valid && !ld_ready && !st_ready));

   // R6
   inorder_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_valid && mode != 2'd2) |-> (mst_addr == head_addr));

   // R1
   offer_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mst_valid |-> ent_vld[0]);
endmodule

bind sb_store_buffer sb_chk #(.DEPTH(DEPTH), .AW(AW)) u_sb_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .ent_vld(ent_vld),
   .head_addr(ent_addr[0]), .st_ready(st_ready), .ld_ready(ld_ready),
   .ld_resp_valid(ld_resp_valid), .mld_valid(mld_valid),
   .mld_resp_valid(mld_resp_valid), .fence_valid(fence_valid),
   .fence_kind(fence_kind), .mst_valid(mst_valid), .mst_addr(mst_addr)
);

// File: tb/tb_sb_store_buffer.sv
module tb_sb_store_buffer;
   localparam int AW = 4;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'd1;
   logic          st_valid = 1'b0, ld_valid = 1'b0, fence_valid = 1'b0, fence_kind = 1'b0;
   logic [AW-1:0] st_addr = '0, ld_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          st_ready, ld_ready, ld_resp_valid, fence_ready;
   logic [DW-1:0] ld_resp_data, mst_data;
   logic          mst_valid, mst_ready, mld_valid, mld_ready;
   logic [AW-1:0] mst_addr, mld_addr;
   logic          mld_resp_valid = 1'b0;
   logic [DW-1:0] mld_resp_data = '0;

   logic          st_gate = 1'b0, blk_en = 1'b0, mem_clr = 1'b0;
   logic [AW-1:0] blk_addr = '0;
   logic [DW-1:0] mem [16];
   logic [AW-1:0] log_a [16];
   int            log_n = 0;
   int            checks = 0, fails = 0;

   always #5 clk = ~clk;

   assign mst_ready = st_gate && !(blk_en && mst_addr == blk_addr);
   assign mld_ready = 1'b1;

   always @(posedge clk) begin
      if (mem_clr) begin
         for (int i = 0; i < 16; i++) mem[i] <= 16'h1000 + 16'(i);
         log_n <= 0;
      end else if (mst_valid && mst_ready) begin
         mem[mst_addr] <= mst_data;
         log_a[log_n[3:0]] <= mst_addr;
         log_n <= log_n + 1;
      end
      mld_resp_valid <= mld_valid && mld_ready;
      mld_resp_data  <= mem[mld_addr];
   end

   sb_store_buffer #(.AW(AW), .DW(DW), .DEPTH(8)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
      .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
      .ld_resp_valid(ld_resp_valid), .ld_resp_data(ld_resp_data),
      .fence_valid(fence_valid), .fence_kind(fence_kind), .fence_ready(fence_ready),
      .mst_valid(mst_valid), .mst_ready(mst_ready), .mst_addr(mst_addr), .mst_data(mst_data),
      .mld_valid(mld_valid), .mld_ready(mld_ready), .mld_addr(mld_addr),
      .mld_resp_valid(mld_resp_valid), .mld_resp_data(mld_resp_data)
   );

   typedef struct packed {
      logic [1:0]    m;
      logic [AW-1:0] aa;
      logic [DW-1:0] da;
      logic [AW-1:0] ab;
      logic [DW-1:0] db;
      logic [AW-1:0] la;
      logic [DW-1:0] exp;
      logic          stall;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{2'd1, 4'd3, 16'h0011, 4'd5, 16'h0022, 4'd3, 16'h0011, 1'b0},
      '{2'd1, 4'd3, 16'h0011, 4'd3, 16'h0022, 4'd3, 16'h0022, 1'b0},
      '{2'd1, 4'd3, 16'h0011, 4'd5, 16'h0022, 4'd7, 16'h1007, 1'b0},
      '{2'd2, 4'd2, 16'h0033, 4'd2, 16'h0044, 4'd2, 16'h0044, 1'b0},
      '{2'd2, 4'd2, 16'h0033, 4'd6, 16'h0044, 4'd9, 16'h1009, 1'b0},
      '{2'd0, 4'd4, 16'h0055, 4'd6, 16'h0066, 4'd4, 16'h0055, 1'b1},
      '{2'd0, 4'd4, 16'h0055, 4'd6, 16'h0066, 4'd8, 16'h1008, 1'b0},
      '{2'd3, 4'd1, 16'h0077, 4'd1, 16'h0088, 4'd1, 16'h0088, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] m);
      rst_n = 1'b0; mode = m; st_valid = 1'b0; ld_valid = 1'b0; fence_valid = 1'b0;
      fence_kind = 1'b0; st_gate = 1'b0; blk_en = 1'b0; mem_clr = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; mem_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
      int n = 0;
      st_valid = 1'b1; st_addr = a; st_data = d;
      #1;
      while (!st_ready && n < 100) begin @(negedge clk); #1; n++; end
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic do_load(input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output int stall_n, output int lat);
      int n = 0;
      ld_valid = 1'b1; ld_addr = a;
      #1;
      while (!ld_ready && n < 200) begin
         if (n == 4) st_gate = 1'b1;
         @(negedge clk); #1; n++;
      end
      stall_n = n;
      @(negedge clk);
      ld_valid = 1'b0;
      #1;
      lat = 0;
      while (!ld_resp_valid && lat < 50) begin @(negedge clk); #1; lat++; end
      d = ld_resp_data;
   endtask

   task automatic wait_log(input int k);
      int n = 0;
      while (log_n < k && n < 100) begin @(negedge clk); n++; end
      #1;
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
      #1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic [DW-1:0] d;
      int sn, lat;
      string req;

      // R1 reset state
      do_reset(2'd1);
      fence_kind = 1'b1; #1;
      chk(st_ready == 1'b1, "R1 st_ready", 32'(st_ready), 1);
      chk(mst_valid == 1'b0, "R1 mst_valid", 32'(mst_valid), 0);
      chk(ld_resp_valid == 1'b0, "R1 ld_resp_valid", 32'(ld_resp_valid), 0);
      chk(fence_ready == 1'b1, "R1 fence_ready", 32'(fence_ready), 1);
      fence_kind = 1'b0;

      // vector table: two stores held back, then one load
      for (int v = 0; v < NV; v++) begin
         do_reset(VEC[v].m);
         push(VEC[v].aa, VEC[v].da);
         push(VEC[v].ab, VEC[v].db);
         do_load(VEC[v].la, d, sn, lat);
         if (VEC[v].stall) req = "R4";
         else if (VEC[v].la == VEC[v].aa || VEC[v].la == VEC[v].ab) req = "R5";
         else req = "R3";
         chk(d == VEC[v].exp, req, 32'(d), 32'(VEC[v].exp));
         chk((sn >= 4) == VEC[v].stall, {req, " stall"}, 32'(sn), 32'(VEC[v].stall));
         if (req == "R5") chk(lat == 0, "R5 latency", 32'(lat), 0);
         if (req == "R3") chk(log_n == 0, "R3 stores still pending", 32'(log_n), 0);
      end

      // R2 full buffer, then R6 drain order
      do_reset(2'd1);
      for (int i = 0; i < 8; i++) push(4'(i), 16'h0200 + 16'(i));
      #1;
      chk(st_ready == 1'b0, "R2 full", 32'(st_ready), 0);
      st_gate = 1'b1;
      wait_log(8);
      for (int i = 0; i < 8; i++)
         chk(log_a[i] == 4'(i), "R6 fifo order", 32'(log_a[i]), 32'(i));

      // R6 refused head is re-offered in strict, total and alternate-total modes
      for (int k = 0; k < 3; k++) begin
         do_reset(k == 0 ? 2'd0 : (k == 1 ? 2'd1 : 2'd3));
         blk_en = 1'b1; blk_addr = 4'd1; st_gate = 1'b1;
         push(4'd1, 16'h0301);
         push(4'd2, 16'h0302);
         idle(5);
         chk(log_n == 0, "R6 no bypass of head", 32'(log_n), 0);
         chk(mst_addr == 4'd1, "R6 head offered", 32'(mst_addr), 1);
         blk_en = 1'b0;
         wait_log(2);
         chk(log_a[0] == 4'd1 && log_a[1] == 4'd2, "R6 order",
             {24'(log_a[0]), 4'h0, log_a[1]}, 32'h0102);
      end

      // R7 and R8 partial order: refused address skipped, same address kept in order
      do_reset(2'd2);
      push(4'd1, 16'h0A01);
      push(4'd2, 16'h0B02);
      push(4'd1, 16'h0A02);
      push(4'd3, 16'h0C03);
      blk_en = 1'b1; blk_addr = 4'd1; st_gate = 1'b1;
      wait_log(2);
      chk(log_n == 2, "R7 two stores passed", 32'(log_n), 2);
      chk(log_a[0] == 4'd2, "R7 first retired", 32'(log_a[0]), 2);
      chk(log_a[1] == 4'd3, "R7 second retired", 32'(log_a[1]), 3);
      blk_en = 1'b0;
      wait_log(4);
      chk(log_a[2] == 4'd1 && log_a[3] == 4'd1, "R8 same address last", 32'(log_n), 4);
      chk(mem[1] == 16'h0A02, "R8 final value", 32'(mem[1]), 32'h0A02);

      // R9 store barrier in partial order
      do_reset(2'd2);
      push(4'd1, 16'h0D01);
      fence_valid = 1'b1; fence_kind = 1'b0;
      #1;
      chk(fence_ready == 1'b1, "R9 barrier accepted", 32'(fence_ready), 1);
      @(negedge clk);
      fence_valid = 1'b0;
      push(4'd2, 16'h0D02);
      blk_en = 1'b1; blk_addr = 4'd1; st_gate = 1'b1;
      idle(8);
      chk(log_n == 0, "R9 younger held", 32'(log_n), 0);
      blk_en = 1'b0;
      wait_log(2);
      chk(log_a[0] == 4'd1 && log_a[1] == 4'd2, "R9 order",
          {24'(log_a[0]), 4'h0, log_a[1]}, 32'h0102);

      // R10 serialize drains before loads
      do_reset(2'd1);
      push(4'd5, 16'h0E05);
      fence_valid = 1'b1; fence_kind = 1'b1;
      ld_valid = 1'b1; ld_addr = 4'd9;
      #1;
      chk(fence_ready == 1'b0, "R10 fence waits", 32'(fence_ready), 0);
      chk(st_ready == 1'b0, "R10 stores held", 32'(st_ready), 0);
      chk(ld_ready == 1'b0 && mld_valid == 1'b0, "R10 load held",
          {30'h0, ld_ready, mld_valid}, 0);
      idle(3);
      chk(mld_valid == 1'b0, "R10 load still held", 32'(mld_valid), 0);
      ld_valid = 1'b0;
      st_gate = 1'b1;
      begin
         int n = 0;
         while (!fence_ready && n < 20) begin @(negedge clk); #1; n++; end
      end
      chk(fence_ready == 1'b1, "R10 fence done", 32'(fence_ready), 1);
      chk(mem[5] == 16'h0E05, "R10 drained", 32'(mem[5]), 32'h0E05);
      fence_valid = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule